// File: doc/BRIEF.md
# Serial Frame Port with Busy Handshake

This block sits on the device side of a general-purpose serial link between an external host and the device's internal frame buffers. The block drives one bit clock, divided down from the core clock to roughly 10 MHz, on both the transmit and the receive clock pins. On the transmit side, the host presents one data bit per bit period and frames it with a transmit enable. The block samples each bit at the falling bit-clock edge and packs the bits into bytes, least significant bit first. It writes the bytes one after another into the frame buffer it currently owns.

When the enable drops, the frame is closed and a one-cycle completion pulse reports its length and whether it was truncated. A busy flag rises as soon as a frame starts. It stays high until the frame is closed and the buffer manager has granted a fresh buffer through a request/grant handshake. The host must not start a new frame while busy is high.

On the receive side, the block pulls bytes from an internal frame source and shifts them out, least significant bit first, on the falling bit-clock edge. A receive enable qualifies the data line. The collision output is held low at all times.

Transmit states: ALLOC (requesting a buffer, busy high), IDLE (buffer owned, busy low), RECV (collecting bits), CLOSE (one cycle, reports the frame). Transmit transitions: ALLOC→IDLE on grant; IDLE→RECV when enable is sampled high; RECV→CLOSE when enable is sampled low; CLOSE→ALLOC always. Receive states: IDLE, SEND, GAP. Receive transitions: IDLE→SEND at a falling edge with a byte available; SEND→SEND after the eighth bit when another byte is available and the last one sent was not final; SEND→GAP after the eighth bit of the final byte, or when no byte is available; GAP→IDLE at the next falling edge.

Top module: `sfp_port`

## Requirements
- R1: `tx_clk_o` and `rx_clk_o` are the same square wave with a period of 2*HALF core cycles; it is low during and right after reset.
- R2: Host bits are sampled in the core cycle just before the bit clock falls, packed least significant bit first, and each completed byte is written with one `buf_wr_o` pulse at consecutive addresses starting at 0.
- R3: A frame ends when `tx_en_i` is sampled low. Trailing bits that do not fill a byte are dropped. `frame_done_o` pulses for exactly one cycle with `frame_len_o` equal to the number of bytes stored.
- R4: `tx_busy_o` is high one core cycle after the first sampled high enable of a frame, well inside the 120-bit-clock limit.
- R5: `tx_busy_o` stays high until the frame is closed and `alloc_gnt_i` has been seen while `alloc_req_o` is high. `alloc_req_o` stays high until the grant arrives, and busy falls in the cycle after the grant.
- R6: At most MAX_BYTES bytes are written (addresses 0..MAX_BYTES-1). Bytes beyond that are discarded, and `frame_ovf_o` is 1 at completion for a truncated frame and 0 for any other frame.
- R7: After reset, `tx_busy_o` and `alloc_req_o` are high until the first grant.
- R8: Receive bytes are shifted out least significant bit first. `rx_dat_o` and `rx_en_o` change only together with a falling bit-clock edge, and `rx_en_o` is high for all 8*N bits of an N-byte frame.
- R9: `src_ready_o` pulses once per byte taken. After the last bit of the byte flagged `src_last_i`, `rx_en_o` goes low for at least one bit period.
- R10: `col_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_clk_o | output | 1 | Transmit bit clock driven to the host |
| tx_en_i | input | 1 | Host transmit enable; high marks valid data |
| tx_dat_i | input | 1 | Host transmit data bit |
| tx_busy_o | output | 1 | Hold-off flag for the next frame |
| col_o | output | 1 | Collision indication, always low |
| rx_clk_o | output | 1 | Receive bit clock driven to the host |
| rx_en_o | output | 1 | High while rx_dat_o carries frame data |
| rx_dat_o | output | 1 | Receive data bit |
| buf_wr_o | output | 1 | Frame buffer byte write strobe |
| buf_addr_o | output | AW | Byte address within the frame buffer |
| buf_wdata_o | output | 8 | Byte written |
| frame_done_o | output | 1 | One-cycle frame completion pulse |
| frame_len_o | output | LW | Bytes stored for the closed frame |
| frame_ovf_o | output | 1 | Frame was truncated at MAX_BYTES |
| alloc_req_o | output | 1 | Request for a fresh transmit buffer |
| alloc_gnt_i | input | 1 | Grant from the buffer manager |
| src_valid_i | input | 1 | Receive source has a byte |
| src_data_i | input | 8 | Receive source byte |
| src_last_i | input | 1 | The byte is the last one of its frame |
| src_ready_o | output | 1 | Byte taken from the source |

## Verification
The bench builds the block with HALF=2, so a bit lasts four core cycles, and MAX_BYTES=4, so a four-byte buffer limit is reached by short frames. With these values, frames of zero to six whole bytes, with and without dangling trailing bits, can all be swept in a few thousand cycles. The sweep covers exact fill, truncation by one and by two bytes, and frames holding only partial bits. A grant latency of five cycles keeps busy visibly high across the allocation wait, and receive frames of one to five bytes exercise byte chaining and the closing gap.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    typedef enum logic [1:0] {
        T_ALLOC,
        T_IDLE,
        T_RECV,
        T_CLOSE
    } tx_state_t;

    typedef enum logic [1:0] {
        R_IDLE,
        R_SEND,
        R_GAP
    } rx_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/sfp_bitclk.sv
module sfp_bitclk #(
    parameter int HALF = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk_o,
    output logic fall_stb_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          bclk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // asserted in the core cycle whose closing edge drops the bit clock
    assign fall_stb_o = bclk && (cnt == LAST);
    assign bclk_o     = bclk;
endmodule

// File: rtl/sfp_tx.sv
module sfp_tx
    import sfp_pkg::*;
#(
    parameter int MAX_BYTES = 1536,
    localparam int AW = $clog2(MAX_BYTES),
    localparam int LW = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_stb,
    input  logic              tx_en_i,
    input  logic              tx_dat_i,
    output logic              busy_o,
    output logic              req_o,
    input  logic              gnt_i,
    output logic              wr_o,
    output logic [AW-1:0]     addr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              done_o,
    output logic [LW-1:0]     len_o,
    output logic              ovf_o
);
    localparam logic [LW-1:0] LIMIT = LW'(MAX_BYTES);

    tx_state_t         st, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [2:0]        bitcnt;
    logic [BYTE_W-1:0] byte_w;

    assign byte_w = {tx_dat_i, shreg[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) st <= T_ALLOC;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            T_ALLOC: if (gnt_i)               nxt = T_IDLE;
            T_IDLE:  if (fall_stb && tx_en_i)  nxt = T_RECV;
            T_RECV:  if (fall_stb && !tx_en_i) nxt = T_CLOSE;
            T_CLOSE:                           nxt = T_ALLOC;
            default:                           nxt = T_ALLOC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b1;
            req_o  <= 1'b1;
        end else begin
            busy_o <= (nxt != T_IDLE);
            req_o  <= (nxt == T_ALLOC);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bitcnt  <= '0;
            wr_o    <= 1'b0;
            addr_o  <= '0;
            wdata_o <= '0;
            done_o  <= 1'b0;
            len_o   <= '0;
            ovf_o   <= 1'b0;
        end else begin
            wr_o   <= 1'b0;
            done_o <= 1'b0;
            unique case (st)
                T_IDLE: begin
                    if (fall_stb && tx_en_i) begin
                        shreg  <= {tx_dat_i, {(BYTE_W-1){1'b0}}};
                        bitcnt <= 3'd1;
                        len_o  <= '0;
                        ovf_o  <= 1'b0;
                    end
                end
                T_RECV: begin
                    if (fall_stb && tx_en_i) begin
                        shreg <= byte_w;
                        if (bitcnt == 3'd7) begin
                            bitcnt <= '0;
                            if (len_o < LIMIT) begin
                                wr_o    <= 1'b1;
                                addr_o  <= len_o[AW-1:0];
                                wdata_o <= byte_w;
                                len_o   <= len_o + 1'b1;
                            end else begin
                                ovf_o <= 1'b1;
                            end
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                T_CLOSE: done_o <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sfp_rx.sv
module sfp_rx
    import sfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_stb,
    input  logic              src_valid_i,
    input  logic [BYTE_W-1:0] src_data_i,
    input  logic              src_last_i,
    output logic              src_ready_o,
    output logic              rx_en_o,
    output logic              rx_dat_o
);
    rx_state_t         st, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [2:0]        bitcnt;
    logic              last_q;
    logic              byte_end;
    logic              load;

    assign byte_end = (st == R_SEND) && fall_stb && (bitcnt == 3'd7);
    assign load = ((st == R_IDLE) && fall_stb && src_valid_i) ||
                  (byte_end && !last_q && src_valid_i);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= R_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            R_IDLE: if (fall_stb && src_valid_i) nxt = R_SEND;
            R_SEND: if (byte_end && (last_q || !src_valid_i)) nxt = R_GAP;
            R_GAP:  if (fall_stb) nxt = R_IDLE;
            default: nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_en_o <= 1'b0;
        else        rx_en_o <= (nxt == R_SEND);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg       <= '0;
            bitcnt      <= '0;
            last_q      <= 1'b0;
            src_ready_o <= 1'b0;
            rx_dat_o    <= 1'b0;
        end else begin
            src_ready_o <= 1'b0;
            if (load) begin
                shreg       <= src_data_i;
                bitcnt      <= '0;
                last_q      <= src_last_i;
                src_ready_o <= 1'b1;
                rx_dat_o    <= src_data_i[0];
            end else if (byte_end) begin
                rx_dat_o <= 1'b0;
            end else if ((st == R_SEND) && fall_stb) begin
                shreg    <= {1'b0, shreg[BYTE_W-1:1]};
                rx_dat_o <= shreg[1];
                bitcnt   <= bitcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfp_port.sv
module sfp_port
    import sfp_pkg::*;
#(
    parameter int HALF      = 6,
    parameter int MAX_BYTES = 1536,
    localparam int AW = $clog2(MAX_BYTES),
    localparam int LW = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              tx_clk_o,
    input  logic              tx_en_i,
    input  logic              tx_dat_i,
    output logic              tx_busy_o,
    output logic              col_o,
    output logic              rx_clk_o,
    output logic              rx_en_o,
    output logic              rx_dat_o,
    output logic              buf_wr_o,
    output logic [AW-1:0]     buf_addr_o,
    output logic [BYTE_W-1:0] buf_wdata_o,
    output logic              frame_done_o,
    output logic [LW-1:0]     frame_len_o,
    output logic              frame_ovf_o,
    output logic              alloc_req_o,
    input  logic              alloc_gnt_i,
    input  logic              src_valid_i,
    input  logic [BYTE_W-1:0] src_data_i,
    input  logic              src_last_i,
    output logic              src_ready_o
);
    logic bclk;
    logic fall_stb;

    sfp_bitclk #(.HALF(HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .bclk_o(bclk), .fall_stb_o(fall_stb)
    );

    sfp_tx #(.MAX_BYTES(MAX_BYTES)) u_tx (
        .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb),
        .tx_en_i(tx_en_i), .tx_dat_i(tx_dat_i),
        .busy_o(tx_busy_o), .req_o(alloc_req_o), .gnt_i(alloc_gnt_i),
        .wr_o(buf_wr_o), .addr_o(buf_addr_o), .wdata_o(buf_wdata_o),
        .done_o(frame_done_o), .len_o(frame_len_o), .ovf_o(frame_ovf_o)
    );

    sfp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb),
        .src_valid_i(src_valid_i), .src_data_i(src_data_i),
        .src_last_i(src_last_i), .src_ready_o(src_ready_o),
        .rx_en_o(rx_en_o), .rx_dat_o(rx_dat_o)
    );

    assign tx_clk_o = bclk;
    assign rx_clk_o = bclk;
    assign col_o    = 1'b0;
endmodule

// File: rtl/sfp_port_chk.sv
module sfp_port_chk #(
    parameter int MAX_BYTES = 1536,
    localparam int AW = $clog2(MAX_BYTES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fall_stb,
    input logic          tx_en_i,
    input logic          tx_busy_o,
    input logic          alloc_req_o,
    input logic          alloc_gnt_i,
    input logic          buf_wr_o,
    input logic [AW-1:0] buf_addr_o,
    input logic          frame_done_o,
    input logic          rx_dat_o,
    input logic          rx_en_o
);
    // R4: a sampled frame start while idle raises busy on the next edge
    a_r4_busy_prompt: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_stb && tx_en_i && !tx_busy_o) |=> tx_busy_o);

    // R5: busy only drops right after a grant
    a_r5_busy_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy_o) |-> $past(alloc_gnt_i));

    // R5: request held until granted
    a_r5_req_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req_o && !alloc_gnt_i) |=> alloc_req_o);

    // R6: no write beyond the buffer
    a_r6_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_o |-> (int'(buf_addr_o) < MAX_BYTES));

    // R3: completion is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R8: receive outputs only move with a falling bit-clock edge
    a_r8_rx_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fall_stb) |-> ($stable(rx_dat_o) && $stable(rx_en_o)));
endmodule

bind sfp_port sfp_port_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .tx_en_i(tx_en_i),
    .tx_busy_o(tx_busy_o), .alloc_req_o(alloc_req_o), .alloc_gnt_i(alloc_gnt_i),
    .buf_wr_o(buf_wr_o), .buf_addr_o(buf_addr_o), .frame_done_o(frame_done_o),
    .rx_dat_o(rx_dat_o), .rx_en_o(rx_en_o)
);

// File: tb/sim_sfp_port.sv
`timescale 1ns/1ps
module sim_sfp_port;
    localparam int HALF = 2;
    localparam int MAXB = 4;
    localparam int LAT  = 5;
    localparam int AW   = $clog2(MAXB);
    localparam int LW   = $clog2(MAXB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic tx_clk_o, tx_en_i, tx_dat_i, tx_busy_o, col_o;
    logic rx_clk_o, rx_en_o, rx_dat_o;
    logic buf_wr_o, frame_done_o, frame_ovf_o, alloc_req_o, alloc_gnt_i;
    logic [AW-1:0] buf_addr_o;
    logic [7:0] buf_wdata_o, src_data_i;
    logic [LW-1:0] frame_len_o;
    logic src_valid_i, src_last_i, src_ready_o;

    sfp_port #(.HALF(HALF), .MAX_BYTES(MAXB)) u0 (.*);

    int checks = 0, errors = 0;
    logic [7:0] mem [MAXB];
    int wcount = 0, done_seen = 0, got_len = 0, got_ovf = 0, colbad = 0;
    logic [7:0] rxmem [8];
    int rx_n = 0, idx = 0, rdy = 0, bc = 0;
    logic rx_go = 1'b0;
    logic rx_bits [64];

    task automatic chk(bit ok, string msg, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int a, int b);
        return 8'((a * 53 + b * 29 + 7) & 255);
    endfunction

    always @(negedge clk) if (rst_n) begin
        if (buf_wr_o) begin
            mem[buf_addr_o] = buf_wdata_o;
            wcount++;
        end
        if (frame_done_o) begin
            done_seen = 1;
            got_len = int'(frame_len_o);
            got_ovf = int'(frame_ovf_o);
        end
        if (col_o) colbad++;
        if (src_ready_o) begin
            idx++;
            rdy++;
        end
    end

    assign src_valid_i = rx_go && (idx < rx_n);
    assign src_data_i  = (idx < 8) ? rxmem[idx] : 8'h00;
    assign src_last_i  = (idx == rx_n - 1);

    always @(posedge rx_clk_o) if (rx_en_o && bc < 64) begin
        rx_bits[bc] = rx_dat_o;
        bc++;
    end

    // buffer manager model
    initial begin
        alloc_gnt_i = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && alloc_req_o) begin
                for (int w = 0; w < LAT; w++) begin
                    @(negedge clk);
                    chk(tx_busy_o == 1'b1, "R5 busy high while grant pending", tx_busy_o, 1);
                end
                alloc_gnt_i = 1'b1;
                @(negedge clk);
                alloc_gnt_i = 1'b0;
                @(negedge clk);
                chk(tx_busy_o == 1'b0, "R5 busy clear after grant", tx_busy_o, 0);
            end
        end
    end

    task automatic send_frame(int nb, int xb);
        int nbits = nb * 8 + xb;
        int stored = (nb < MAXB) ? nb : MAXB;
        int ovf = (nb > MAXB) ? 1 : 0;
        while (tx_busy_o) @(negedge clk);
        done_seen = 0;
        wcount = 0;
        for (int k = 0; k < nbits; k++) begin
            @(posedge tx_clk_o); #1;
            tx_en_i = 1'b1;
            tx_dat_i = pat(nb, k / 8) >> (k % 8);
        end
        @(posedge tx_clk_o); #1;
        chk(tx_busy_o == 1'b1, "R4 busy up within a bit of frame start", tx_busy_o, 1);
        tx_en_i = 1'b0;
        tx_dat_i = 1'b0;
        while (!done_seen) @(negedge clk);
        chk(got_len == stored, "R3 frame length", got_len, stored);
        chk(wcount == stored, "R2 R6 write count", wcount, stored);
        chk(got_ovf == ovf, "R6 overflow flag", got_ovf, ovf);
        for (int i = 0; i < stored; i++)
            chk(mem[i] == pat(nb, i), "R2 stored byte LSB first", mem[i], pat(nb, i));
        @(negedge clk);
        chk(tx_busy_o == 1'b1 && alloc_req_o == 1'b1, "R5 busy and request after close",
            tx_busy_o, 1);
    endtask

    task automatic rx_frame(int n);
        rx_n = n;
        for (int i = 0; i < 8; i++) rxmem[i] = pat(n + 20, i);
        bc = 0; rdy = 0; idx = 0;
        rx_go = 1'b1;
        while (idx < n) @(negedge clk);
        @(negedge clk);
        while (rx_en_o) @(negedge clk);
        repeat (2 * HALF) @(negedge clk);
        chk(rx_en_o == 1'b0, "R9 enable low after final byte", rx_en_o, 0);
        repeat (4 * HALF) @(negedge clk);
        rx_go = 1'b0;
        chk(bc == 8 * n, "R8 enable spans all bits", bc, 8 * n);
        chk(rdy == n, "R9 one ready per byte", rdy, n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            for (int j = 0; j < 8; j++) b[j] = rx_bits[i * 8 + j];
            chk(b == rxmem[i], "R8 serial byte LSB first", b, rxmem[i]);
        end
    endtask

    initial begin
        tx_en_i = 1'b0;
        tx_dat_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_busy_o == 1'b1, "R7 busy after reset", tx_busy_o, 1);
        chk(alloc_req_o == 1'b1, "R7 request after reset", alloc_req_o, 1);
        chk(tx_clk_o == 1'b0, "R1 bit clock low after reset", tx_clk_o, 0);
        chk(rx_en_o == 1'b0 && buf_wr_o == 1'b0, "R8 idle outputs after reset", rx_en_o, 0);
        begin
            realtime t0;
            @(posedge tx_clk_o); t0 = $realtime;
            @(posedge tx_clk_o);
            chk(int'($realtime - t0) == 2 * HALF * 8, "R1 bit clock period",
                int'($realtime - t0), 2 * HALF * 8);
            #1 chk(rx_clk_o == tx_clk_o, "R1 receive clock equals transmit clock", rx_clk_o, tx_clk_o);
        end
        for (int nb = 0; nb <= 6; nb++) begin
            for (int xs = 0; xs < 2; xs++) begin
                if (nb * 8 + xs * 3 > 0) send_frame(nb, xs * 3);
            end
        end
        for (int n = 1; n <= 5; n++) rx_frame(n);
        chk(colbad == 0, "R10 collision output stays low", colbad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule